// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer

This block lets an I2C bus master issue a repeated start. Software asks for one by pulsing a request input. If the rest of the master reports that it is idle, the block takes over SCL and SDA through two pull-down enables. It then steps the lines through the repeated-start pattern. Each phase is timed by a reload-and-count baud timer whose reload value is an 8-bit input, so one baud period is reload+1 clocks. The block does not step blindly: it moves on only when the synchronised line levels show that the previous step took effect. A slave that stretches SCL therefore lengthens the sequence and does not corrupt it.

The states are ST_IDLE, ST_PULL_SCL, ST_SDA_UP, ST_SCL_UP, ST_BUS_HIGH, ST_SDA_DOWN and ST_HOLD. Their transitions are:
- accept: ST_IDLE or ST_HOLD to ST_PULL_SCL.
- scl_seen_low: ST_PULL_SCL to ST_SDA_UP, loading the timer.
- sda_ok: ST_SDA_UP to ST_SCL_UP, on timer expiry with SDA high.
- scl_seen_high: ST_SCL_UP to ST_BUS_HIGH, loading the timer.
- hold_done: ST_BUS_HIGH to ST_SDA_DOWN, reloading the timer.
- finish: ST_SDA_DOWN to ST_HOLD.
- handover: ST_HOLD to ST_IDLE, when the master leaves idle.
- collide: ST_SCL_UP or ST_BUS_HIGH to ST_IDLE.

The block also raises a start-seen status bit whenever a start pattern appears on the lines. At the end of a good sequence it raises a completion flag. If another agent disturbs the sequence, it raises a collision flag.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A req_set pulse is accepted only when master_idle is 1 and the block is in ST_IDLE or ST_HOLD. Otherwise it has no effect: req_bit stays 0 and both pull-down enables keep their values.
- R2: On acceptance, scl_drive_low goes to 1 and sda_drive_low goes to 0 in the next cycle, and req_bit becomes 1. The timer is loaded only once the two-flop-synchronised SCL reads low. Starting from ST_IDLE with no interference, SCL is therefore driven low for exactly reload+4 clocks.
- R3: While SCL is driven low, SDA is released. SCL is released only after the timer has expired and synchronised SDA reads high. If SDA is held low, SCL stays driven low.
- R4: The timer is reloaded only when synchronised SCL reads high. From the first cycle that bus SCL is high to the first cycle that sda_drive_low is 1, exactly reload+4 clocks pass, however long a slave stretched SCL.
- R5: SDA is driven low with SCL released for exactly reload+1 clocks, which is one baud period.
- R6: When that period expires, four things happen in the same cycle: scl_drive_low becomes 1, sda_drive_low stays 1, req_bit clears, and done_irq sets. done_irq is 0 throughout the sequence before that cycle.
- R7: After completion, both lines stay driven low while master_idle is 1. When master_idle goes to 0, both are released.
- R8: start_seen sets when synchronised SDA goes from 1 to 0 while synchronised SCL is 1 on both samples. It clears on acceptance.
- R9: A collision is flagged if synchronised SDA reads low at the moment synchronised SCL is first seen high in ST_SCL_UP.
- R10: A collision is flagged if synchronised SCL reads low during ST_BUS_HIGH, which is before the block drives SDA low.
- R11: On collision, both enables are released, req_bit clears and done_irq is not set. coll_flag stays 1 until coll_clr, and done_irq stays 1 until irq_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | Software pulse requesting a repeated start |
| master_idle | input | 1 | 1 when the rest of the master has no bus event in progress |
| baud_reload | input | 8 | Baud timer reload; one period is reload+1 clocks |
| irq_clr | input | 1 | Clears done_irq |
| coll_clr | input | 1 | Clears coll_flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| req_bit | output | 1 | Request bit; clears itself at the end of a sequence |
| start_seen | output | 1 | Start pattern detected on the lines |
| done_irq | output | 1 | Sequence completed (sticky) |
| coll_flag | output | 1 | Bus collision detected (sticky) |

## Verification
The bench targets these corner cases:
- Stretching. A slave holds SCL low for a random number of cycles after release. A design that started its timer at release, rather than at the sampled rising edge, would shorten the high period and fail the reload+4 gap.
- SDA held low. SDA is held low past the first timer expiry. A design that ignored the SDA check would release SCL early.
- Collisions. A forced SDA low is applied as SCL rises, and an SCL pulse is applied during the both-high period. A design that missed either case would go on to raise done_irq.
- Request handling. Requests are pulsed while the master is busy and again mid-sequence. A design that accepted them would restart the sequence or stretch its phases.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL_SCL,
        ST_SDA_UP,
        ST_SCL_UP,
        ST_BUS_HIGH,
        ST_SDA_DOWN,
        ST_HOLD
    } rs_state_t;

    // Pull-down enable pair for one state: {scl, sda}
    typedef struct packed {
        logic scl;
        logic sda;
    } rs_drive_t;

endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    // Released open-drain lines read high, so the flops reset to 1
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                end
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rs_baud_timer.sv
module rs_baud_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] reload,
    output logic             expired
);

    logic [WIDTH-1:0] count;
    logic             armed;

    // Counts down from reload to zero and parks there: expiry holds
    // until the next load, so a phase waiting on a line level sees it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (load) begin
            count <= reload;
            armed <= 1'b1;
        end else if (armed && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    assign expired = armed && (count == '0);

endmodule

// File: rtl/rs_start_detect.sv
module rs_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_pulse
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // SDA falls while SCL is high on both samples
    assign start_pulse = sda_q && !sda_s && scl_q && scl_s;

endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
    import rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic master_idle,
    input  logic irq_clr,
    input  logic coll_clr,
    input  logic scl_s,
    input  logic sda_s,
    input  logic tmr_expired,
    input  logic start_pulse,
    output logic tmr_load,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic req_bit,
    output logic start_seen,
    output logic done_irq,
    output logic coll_flag
);

    rs_state_t state;
    rs_state_t state_nxt;
    logic      ev_accept;
    logic      ev_collide;
    logic      ev_finish;
    rs_drive_t drv;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt  = state;
        tmr_load   = 1'b0;
        ev_accept  = 1'b0;
        ev_collide = 1'b0;
        ev_finish  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_set && master_idle) begin
                    ev_accept = 1'b1;
                    state_nxt = ST_PULL_SCL;
                end
            end
            ST_HOLD: begin
                if (req_set && master_idle) begin
                    ev_accept = 1'b1;
                    state_nxt = ST_PULL_SCL;
                end else if (!master_idle) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_PULL_SCL: begin
                if (!scl_s) begin
                    tmr_load  = 1'b1;
                    state_nxt = ST_SDA_UP;
                end
            end
            ST_SDA_UP: begin
                if (tmr_expired && sda_s) begin
                    state_nxt = ST_SCL_UP;
                end
            end
            ST_SCL_UP: begin
                if (scl_s) begin
                    if (!sda_s) begin
                        ev_collide = 1'b1;
                        state_nxt  = ST_IDLE;
                    end else begin
                        tmr_load  = 1'b1;
                        state_nxt = ST_BUS_HIGH;
                    end
                end
            end
            ST_BUS_HIGH: begin
                if (!scl_s) begin
                    ev_collide = 1'b1;
                    state_nxt  = ST_IDLE;
                end else if (tmr_expired) begin
                    tmr_load  = 1'b1;
                    state_nxt = ST_SDA_DOWN;
                end
            end
            ST_SDA_DOWN: begin
                if (tmr_expired) begin
                    ev_finish = 1'b1;
                    state_nxt = ST_HOLD;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Line drives per state
    always_comb begin
        unique case (state)
            ST_PULL_SCL: drv = '{scl: 1'b1, sda: 1'b0};
            ST_SDA_UP:   drv = '{scl: 1'b1, sda: 1'b0};
            ST_SDA_DOWN: drv = '{scl: 1'b0, sda: 1'b1};
            ST_HOLD:     drv = '{scl: 1'b1, sda: 1'b1};
            default:     drv = '{scl: 1'b0, sda: 1'b0};
        endcase
    end

    assign scl_drive_low = drv.scl;
    assign sda_drive_low = drv.sda;

    // Status and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_bit    <= 1'b0;
            start_seen <= 1'b0;
            done_irq   <= 1'b0;
            coll_flag  <= 1'b0;
        end else begin
            if (ev_accept) begin
                req_bit <= 1'b1;
            end else if (ev_collide || ev_finish) begin
                req_bit <= 1'b0;
            end

            if (ev_accept) begin
                start_seen <= 1'b0;
            end else if (start_pulse) begin
                start_seen <= 1'b1;
            end

            if (ev_finish) begin
                done_irq <= 1'b1;
            end else if (irq_clr) begin
                done_irq <= 1'b0;
            end

            if (ev_collide) begin
                coll_flag <= 1'b1;
            end else if (coll_clr) begin
                coll_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
    parameter int BAUD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_set,
    input  logic              master_idle,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              irq_clr,
    input  logic              coll_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              req_bit,
    output logic              start_seen,
    output logic              done_irq,
    output logic              coll_flag
);

    localparam int NLINES = 2;
    localparam int IX_SCL = 1;
    localparam int IX_SDA = 0;

    logic [NLINES-1:0] lines_sync;
    logic              scl_s;
    logic              sda_s;
    logic              tmr_load;
    logic              tmr_expired;
    logic              start_pulse;

    rs_line_sync #(
        .LINES  (NLINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (lines_sync)
    );

    assign scl_s = lines_sync[IX_SCL];
    assign sda_s = lines_sync[IX_SDA];

    rs_baud_timer #(
        .WIDTH (BAUD_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .reload  (baud_reload),
        .expired (tmr_expired)
    );

    rs_start_detect u_sdet (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .start_pulse (start_pulse)
    );

    rs_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_set       (req_set),
        .master_idle   (master_idle),
        .irq_clr       (irq_clr),
        .coll_clr      (coll_clr),
        .scl_s         (scl_s),
        .sda_s         (sda_s),
        .tmr_expired   (tmr_expired),
        .start_pulse   (start_pulse),
        .tmr_load      (tmr_load),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .req_bit       (req_bit),
        .start_seen    (start_seen),
        .done_irq      (done_irq),
        .coll_flag     (coll_flag)
    );

endmodule

// File: rtl/rs_seq_checker.sv
module rs_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic req_set,
    input logic master_idle,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic req_bit,
    input logic done_irq,
    input logic coll_flag
);

    assert_accept_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_bit) |-> $past(req_set && master_idle));

    assert_scl_release_sda_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> !sda_drive_low);

    assert_sda_low_with_scl_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_drive_low);

    assert_done_clears_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> ($past(req_bit) && !req_bit && scl_drive_low && sda_drive_low));

    assert_coll_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> (!scl_drive_low && !sda_drive_low && !req_bit));

    assert_scl_pull_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> (req_bit || done_irq));

endmodule

bind i2c_rstart_seq rs_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_set       (req_set),
    .master_idle   (master_idle),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .req_bit       (req_bit),
    .done_irq      (done_irq),
    .coll_flag     (coll_flag)
);

// File: tb/sim_i2c_rstart_seq.sv
module sim_i2c_rstart_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LOOP_MAX   = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_set = 1'b0;
    logic       master_idle = 1'b1;
    logic [7:0] baud_reload = 8'd4;
    logic       irq_clr = 1'b0;
    logic       coll_clr = 1'b0;
    logic       scl_ext = 1'b0;
    logic       sda_ext = 1'b0;
    logic       scl_bus;
    logic       sda_bus;
    logic       scl_drive_low, sda_drive_low, req_bit, start_seen, done_irq, coll_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    assign scl_bus = !(scl_drive_low || scl_ext);
    assign sda_bus = !(sda_drive_low || sda_ext);

    i2c_rstart_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .master_idle(master_idle),
        .baud_reload(baud_reload), .irq_clr(irq_clr), .coll_clr(coll_clr),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .req_bit(req_bit), .start_seen(start_seen), .done_irq(done_irq),
        .coll_flag(coll_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_low(int r);   return r + 4; endfunction
    function automatic int exp_gap(int r);   return r + 4; endfunction
    function automatic int exp_sdadn(int r); return r + 1; endfunction

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_req();
        req_set = 1'b1;
        step();
        req_set = 1'b0;
    endtask

    task automatic finish_hold();
        master_idle = 1'b0;
        step();
        step();
        chk(!scl_drive_low && !sda_drive_low, "R7 released after handover",
            {scl_drive_low, sda_drive_low}, 0);
        master_idle = 1'b1;
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        step();
        chk(!done_irq, "R11 irq_clr clears done_irq", done_irq, 0);
    endtask

    task automatic run_seq(input int r, input int stretch, input bit poke);
        int cnt;
        bit sda_bad;
        baud_reload = 8'(r);
        pulse_req();
        chk(req_bit && scl_drive_low && !sda_drive_low, "R2 acceptance",
            {req_bit, scl_drive_low, sda_drive_low}, 3'b110);
        chk(!start_seen, "R8 cleared on accept", start_seen, 0);
        cnt = 0; sda_bad = 0;
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (!scl_drive_low) break;
            if (sda_drive_low) sda_bad = 1;
            cnt++;
            step();
        end
        chk(cnt == exp_low(r), "R2 scl low length", cnt, exp_low(r));
        chk(!sda_bad, "R3 sda released while scl low", sda_bad, 0);
        if (stretch > 0) begin
            scl_ext = 1'b1;
            for (int i = 0; i < stretch; i++) step();
            scl_ext = 1'b0;
        end
        cnt = 0;
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (sda_drive_low) break;
            req_set = (poke && cnt == 1);
            cnt++;
            step();
        end
        req_set = 1'b0;
        chk(cnt == exp_gap(r), "R4 high-to-sda-low gap", cnt, exp_gap(r));
        cnt = 0; sda_bad = 0;
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (scl_drive_low) break;
            if (done_irq) sda_bad = 1;
            cnt++;
            step();
        end
        chk(cnt == exp_sdadn(r), "R5 sda low length", cnt, exp_sdadn(r));
        chk(!sda_bad, "R6 no early done_irq", sda_bad, 0);
        chk(done_irq && sda_drive_low && !req_bit && !coll_flag, "R6 completion",
            {done_irq, sda_drive_low, req_bit, coll_flag}, 4'b1100);
        step(); step(); step();
        chk(start_seen, "R8 start seen", start_seen, 1);
        chk(scl_drive_low && sda_drive_low, "R7 hold both low",
            {scl_drive_low, sda_drive_low}, 3);
        finish_hold();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !req_bit && !done_irq && !coll_flag && !start_seen,
            "reset state", {scl_drive_low, sda_drive_low, req_bit, done_irq, coll_flag, start_seen}, 0);
        rst_n = 1'b1;
        step();

        // R1: request while master busy is ignored
        master_idle = 1'b0;
        pulse_req();
        for (int i = 0; i < 6; i++) step();
        chk(!req_bit && !scl_drive_low && !sda_drive_low, "R1 busy request ignored",
            {req_bit, scl_drive_low, sda_drive_low}, 0);
        master_idle = 1'b1;
        step();

        // directed corners
        run_seq(0, 0, 0);
        run_seq(3, 7, 1);
        run_seq(255, 0, 0);

        // constrained random
        for (int k = 0; k < 12; k++) begin
            run_seq(int'($urandom_range(20, 0)), int'($urandom_range(10, 0)), 1'($urandom_range(1, 0)));
        end

        // R3: SDA held low past expiry keeps SCL driven
        baud_reload = 8'd2;
        pulse_req();
        sda_ext = 1'b1;
        for (int i = 0; i < 15; i++) step();
        chk(scl_drive_low, "R3 scl held while sda low", scl_drive_low, 1);
        sda_ext = 1'b0;
        for (int i = 0; i < 5; i++) step();
        chk(!scl_drive_low, "R3 scl released after sda high", scl_drive_low, 0);
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (done_irq) break;
            step();
        end
        chk(done_irq && !coll_flag, "R6 completes after sda wait", {done_irq, coll_flag}, 2);
        finish_hold();

        // R9: SDA low when SCL rises
        baud_reload = 8'd6;
        pulse_req();
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (!scl_drive_low) break;
            step();
        end
        sda_ext = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (coll_flag) break;
            step();
        end
        chk(coll_flag, "R9 collision sda low at scl rise", coll_flag, 1);
        chk(!scl_drive_low && !sda_drive_low && !req_bit && !done_irq, "R11 collision release",
            {scl_drive_low, sda_drive_low, req_bit, done_irq}, 0);
        sda_ext = 1'b0;
        for (int i = 0; i < 5; i++) step();
        chk(coll_flag, "R11 coll_flag sticky", coll_flag, 1);
        coll_clr = 1'b1;
        step();
        coll_clr = 1'b0;
        step();
        chk(!coll_flag, "R11 coll_clr clears", coll_flag, 0);

        // R10: SCL pulled low during both-high period
        baud_reload = 8'd20;
        pulse_req();
        for (int i = 0; i < LOOP_MAX; i++) begin
            if (!scl_drive_low) break;
            step();
        end
        for (int i = 0; i < 6; i++) step();
        scl_ext = 1'b1;
        for (int i = 0; i < 3; i++) step();
        scl_ext = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (coll_flag) break;
            step();
        end
        chk(coll_flag && !sda_drive_low, "R10 collision scl low early",
            {coll_flag, sda_drive_low}, 2);
        for (int i = 0; i < 30; i++) step();
        chk(!done_irq && !req_bit && !sda_drive_low && !scl_drive_low, "R11 no completion after collision",
            {done_irq, req_bit, sda_drive_low, scl_drive_low}, 0);
        coll_clr = 1'b1;
        step();
        coll_clr = 1'b0;
        step();

        summary();
        $finish;
    end

endmodule